// File: doc/BRIEF.md
# Floating-Point System Register Transfer Unit

This block carries the two system registers of a floating-point unit, the control/status word and the 32-bit transfer register, to and from the integer general registers and memory. It takes one 16-bit instruction word at a time. A word that carries an instruction but does not name a system transfer is reported as illegal.

Four transfer kinds exist: copy a system register into a general register, copy a general register into a system register, push a system register to memory, and pop one from memory. A push lowers the address register by one word before the store. A pop loads from the address register and then raises it by one word. Memory traffic goes out as single-word requests over a request/ready handshake. While a request is outstanding the unit reports busy and ignores new words. The address register is written back only in the cycle the handshake completes.

The control word keeps only its low 22 bits, and its rounding, denormal, precision, transfer-size and bank fields are driven out as separate ports. The general register file and the memory live outside this block and are reached through its ports.

Top module: `fsr_xfer_unit`

## Requirements
- R1: After reset the control word equals the CTRL_RESET parameter with bits 31:22 cleared, the transfer register is zero, busy is low and no memory request is raised.
- R2: Instruction bit 4 chooses the system register: 1 selects the transfer register, 0 selects the control word.
- R3: A word whose bits 15:12 and 7:0 match 0x0_5A or 0x0_6A writes the selected system register into general register n (n = bits 11:8), with gpr_we high in the same cycle as the accepted word.
- R4: A word matching 0x4_5A or 0x4_6A copies general register n into the selected system register, which shows the value from the next cycle. For the control word, bits 31:22 read back as zero.
- R5: A word matching 0x4_52 or 0x4_62 raises a write request at address Rn-4 carrying the selected register. Busy stays high until mem_ready is seen.
- R6: A word matching 0x4_56 or 0x4_66 raises a read request at address Rn. When mem_ready is seen, the selected register takes mem_rdata (masked for the control word).
- R7: During a memory transfer gpr_we stays low. In the cycle mem_ready is high, gpr_we pulses with index n and the new address (Rn-4 for a push, Rn+4 for a pop).
- R8: An accepted word that matches none of the patterns above pulses illegal in that cycle and changes no register, general register or memory request.
- R9: Port fields follow the control word: rounding mode = bits 1:0, denorm flush = bit 18, double precision = bit 19, pair transfer = bit 20, bank select = bit 21.
- R10: Words presented while busy are ignored.
- R11: While a request waits for mem_ready, its address, write data and direction hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction word |
| busy | output | 1 | Memory transfer in progress; words are not accepted |
| illegal | output | 1 | Accepted word is not a system transfer |
| gpr_idx | output | 4 | General register index being read or written |
| gpr_rdata | input | 32 | Content of general register gpr_idx |
| gpr_we | output | 1 | General register write strobe |
| gpr_wdata | output | 32 | General register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| ctrl_word | output | 32 | Control word |
| comm_word | output | 32 | Transfer register |
| rnd_mode | output | 2 | Rounding mode field |
| denorm_flush | output | 1 | Denormal flush field |
| prec_double | output | 1 | Precision field |
| pair_xfer | output | 1 | Transfer-size field |
| bank_sel | output | 1 | Register bank field |

## Verification
The bench goes after the select bit applied to every form, because a swapped select would move the wrong system register and leave the other one stale. It writes all ones into the control word and reads it back. A missing mask would show bits 31:22 set. It pushes from address zero and pops from 0xFFFFFFFC to cover wraparound. A design that updated the address register at request time, or from a stale value, would show the wrong index or value on the write strobe. Random words, including near-miss patterns, are also sent while a transfer waits, where a design that accepted them would corrupt registers or send illegal pulses.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_TO_GPR,
    OP_FROM_GPR,
    OP_PUSH,
    OP_POP,
    OP_ILLEGAL
  } fsr_op_e;

  typedef enum logic {
    ST_IDLE,
    ST_MEM
  } fsr_state_e;

  localparam logic [15:0] MATCH_MASK = 16'hF0FF;
  localparam int unsigned SEL_BIT    = 4;

  localparam int unsigned FLD_RND_LO = 0;
  localparam int unsigned FLD_DN     = 18;
  localparam int unsigned FLD_PR     = 19;
  localparam int unsigned FLD_SZ     = 20;
  localparam int unsigned FLD_FR     = 21;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
#(
  parameter int unsigned IW    = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             valid,
  input  logic [IW-1:0]    word,
  output fsr_op_e          op,
  output logic             sel_comm,
  output logic [IDX_W-1:0] idx
);
  logic [IW-1:0] masked;

  assign masked   = word & MATCH_MASK;
  assign sel_comm = word[SEL_BIT];
  assign idx      = word[8 +: IDX_W];

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      unique case (masked)
        16'h005A, 16'h006A: op = OP_TO_GPR;
        16'h405A, 16'h406A: op = OP_FROM_GPR;
        16'h4052, 16'h4062: op = OP_PUSH;
        16'h4056, 16'h4066: op = OP_POP;
        default:            op = OP_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/fsr_sysregs.sv
module fsr_sysregs #(
  parameter int unsigned    DW         = 32,
  parameter logic [DW-1:0]  CTRL_RESET = 32'h0004_0001,
  parameter logic [DW-1:0]  CTRL_WMASK = 32'h003F_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_comm,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] comm_q
);
  localparam logic [DW-1:0] CTRL_INIT = CTRL_RESET & CTRL_WMASK;

  logic [DW-1:0] ctrl_d, comm_d;
  logic          ctrl_en, comm_en;

  always_comb begin
    ctrl_en = wr_en & ~wr_comm;
    comm_en = wr_en &  wr_comm;
    ctrl_d  = wr_data & CTRL_WMASK;
    comm_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comm_q <= '0;
    end else if (comm_en) begin
      comm_q <= comm_d;
    end
  end
endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
  import fsr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fsr_op_e          op,
  input  logic             sel_comm,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    store_val,
  input  logic             mem_ready,
  output logic             busy,
  output logic             done,
  output logic             done_load,
  output logic             held_comm,
  output logic [IDX_W-1:0] held_idx,
  output logic [DW-1:0]    held_wb,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  fsr_state_e       st_q, st_d;
  logic             we_d, comm_d;
  logic [IDX_W-1:0] idx_d;
  logic [DW-1:0]    addr_d, wdata_d, wb_d;
  logic             start;

  assign start = (op == OP_PUSH) || (op == OP_POP);

  always_comb begin
    st_d    = st_q;
    we_d    = mem_we;
    comm_d  = held_comm;
    idx_d   = held_idx;
    addr_d  = mem_addr;
    wdata_d = mem_wdata;
    wb_d    = held_wb;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_MEM;
          comm_d = sel_comm;
          idx_d  = idx;
          if (op == OP_PUSH) begin
            we_d    = 1'b1;
            addr_d  = base - STEP;
            wb_d    = base - STEP;
            wdata_d = store_val;
          end else begin
            we_d    = 1'b0;
            addr_d  = base;
            wb_d    = base + STEP;
            wdata_d = '0;
          end
        end
      end
      ST_MEM: begin
        if (mem_ready) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mem_we    <= 1'b0;
      held_comm <= 1'b0;
      held_idx  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      held_wb   <= '0;
    end else begin
      st_q      <= st_d;
      mem_we    <= we_d;
      held_comm <= comm_d;
      held_idx  <= idx_d;
      mem_addr  <= addr_d;
      mem_wdata <= wdata_d;
      held_wb   <= wb_d;
    end
  end

  assign busy      = (st_q == ST_MEM);
  assign mem_req   = busy;
  assign done      = busy & mem_ready;
  assign done_load = done & ~mem_we;
endmodule

// File: rtl/fsr_xfer_unit.sv
module fsr_xfer_unit
  import fsr_pkg::*;
#(
  parameter int unsigned   DW         = 32,
  parameter int unsigned   IW         = 16,
  parameter int unsigned   IDX_W      = 4,
  parameter logic [31:0]   CTRL_RESET = 32'h0004_0001,
  parameter logic [31:0]   CTRL_WMASK = 32'h003F_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [IW-1:0]    instr_word,
  output logic             busy,
  output logic             illegal,
  output logic [IDX_W-1:0] gpr_idx,
  input  logic [DW-1:0]    gpr_rdata,
  output logic             gpr_we,
  output logic [DW-1:0]    gpr_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    ctrl_word,
  output logic [DW-1:0]    comm_word,
  output logic [1:0]       rnd_mode,
  output logic             denorm_flush,
  output logic             prec_double,
  output logic             pair_xfer,
  output logic             bank_sel
);
  fsr_op_e          op;
  logic             dec_comm;
  logic [IDX_W-1:0] dec_idx;
  logic             accept;
  logic             done, done_load, held_comm;
  logic [IDX_W-1:0] held_idx;
  logic [DW-1:0]    held_wb;
  logic [DW-1:0]    sel_val;
  logic             rf_wr_en, rf_wr_comm;
  logic [DW-1:0]    rf_wr_data;

  assign accept = instr_valid & ~busy;

  fsr_decode #(.IW(IW), .IDX_W(IDX_W)) u_dec (
    .valid    (accept),
    .word     (instr_word),
    .op       (op),
    .sel_comm (dec_comm),
    .idx      (dec_idx)
  );

  assign sel_val = dec_comm ? comm_word : ctrl_word;

  fsr_seq #(.DW(DW), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sel_comm  (dec_comm),
    .idx       (dec_idx),
    .base      (gpr_rdata),
    .store_val (sel_val),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .done_load (done_load),
    .held_comm (held_comm),
    .held_idx  (held_idx),
    .held_wb   (held_wb),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_comm = dec_comm;
    rf_wr_data = gpr_rdata;
    if (done_load) begin
      rf_wr_en   = 1'b1;
      rf_wr_comm = held_comm;
      rf_wr_data = mem_rdata;
    end else if (op == OP_FROM_GPR) begin
      rf_wr_en   = 1'b1;
    end
  end

  fsr_sysregs #(
    .DW         (DW),
    .CTRL_RESET (DW'(CTRL_RESET)),
    .CTRL_WMASK (DW'(CTRL_WMASK))
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_wr_en),
    .wr_comm (rf_wr_comm),
    .wr_data (rf_wr_data),
    .ctrl_q  (ctrl_word),
    .comm_q  (comm_word)
  );

  always_comb begin
    gpr_idx   = busy ? held_idx : dec_idx;
    gpr_we    = 1'b0;
    gpr_wdata = sel_val;
    if (done) begin
      gpr_we    = 1'b1;
      gpr_wdata = held_wb;
    end else if (op == OP_TO_GPR) begin
      gpr_we    = 1'b1;
    end
  end

  assign illegal      = (op == OP_ILLEGAL);
  assign rnd_mode     = ctrl_word[FLD_RND_LO +: 2];
  assign denorm_flush = ctrl_word[FLD_DN];
  assign prec_double  = ctrl_word[FLD_PR];
  assign pair_xfer    = ctrl_word[FLD_SZ];
  assign bank_sel     = ctrl_word[FLD_FR];
endmodule

// File: rtl/fsr_xfer_chk.sv
module fsr_xfer_chk #(
  parameter int unsigned DW         = 32,
  parameter logic [31:0] CTRL_WMASK = 32'h003F_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          illegal,
  input logic          gpr_we,
  input logic [DW-1:0] gpr_rdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic [DW-1:0] ctrl_word,
  input logic [DW-1:0] comm_word
);
  p_ctrl_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & ~DW'(CTRL_WMASK)) == '0);

  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && mem_we) |-> mem_addr == $past(gpr_rdata) - DW'(DW / 8));

  p_pop_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> mem_addr == $past(gpr_rdata));

  p_no_wb_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |-> !gpr_we);

  p_wb_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |-> gpr_we);

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !gpr_we ##1 (!mem_req && $stable(ctrl_word) && $stable(comm_word)));

  p_no_illegal_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !illegal);

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

bind fsr_xfer_unit fsr_xfer_chk #(.DW(DW), .CTRL_WMASK(CTRL_WMASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .illegal   (illegal),
  .gpr_we    (gpr_we),
  .gpr_rdata (gpr_rdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .ctrl_word (ctrl_word),
  .comm_word (comm_word)
);

// File: tb/tb_fsr_xfer_unit.sv
module tb_fsr_xfer_unit;
  localparam logic [31:0] RST_VAL = 32'hFFC4_0001;
  localparam logic [31:0] WMASK   = 32'h003F_FFFF;

  logic        clk, rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        busy, illegal, gpr_we, mem_req, mem_we, mem_ready;
  logic [3:0]  gpr_idx;
  logic [31:0] gpr_rdata, gpr_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] ctrl_word, comm_word;
  logic [1:0]  rnd_mode;
  logic        denorm_flush, prec_double, pair_xfer, bank_sel;

  logic [31:0] gpr_b   [16];
  logic [31:0] exp_gpr [16];
  logic [31:0] exp_ctrl, exp_comm;
  int          checks, fails;

  fsr_xfer_unit #(.CTRL_RESET(RST_VAL), .CTRL_WMASK(WMASK)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .busy(busy), .illegal(illegal), .gpr_idx(gpr_idx), .gpr_rdata(gpr_rdata),
    .gpr_we(gpr_we), .gpr_wdata(gpr_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .ctrl_word(ctrl_word), .comm_word(comm_word),
    .rnd_mode(rnd_mode), .denorm_flush(denorm_flush), .prec_double(prec_double),
    .pair_xfer(pair_xfer), .bank_sel(bank_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign gpr_rdata = gpr_b[gpr_idx];
  always @(posedge clk) if (gpr_we) gpr_b[gpr_idx] <= gpr_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 none-illegal, 1 to gpr, 2 from gpr, 3 push, 4 pop, 5 illegal
  function automatic int kind_of(input logic [15:0] w);
    logic [15:0] m;
    m = w & 16'hF0FF;
    if (m == 16'h005A || m == 16'h006A) return 1;
    if (m == 16'h405A || m == 16'h406A) return 2;
    if (m == 16'h4052 || m == 16'h4062) return 3;
    if (m == 16'h4056 || m == 16'h4066) return 4;
    return 5;
  endfunction

  task automatic compare_state(input string req);
    chk(ctrl_word == exp_ctrl, req, ctrl_word, exp_ctrl);
    chk(comm_word == exp_comm, req, comm_word, exp_comm);
    chk({bank_sel, pair_xfer, prec_double, denorm_flush, rnd_mode} ==
        {exp_ctrl[21], exp_ctrl[20], exp_ctrl[19], exp_ctrl[18], exp_ctrl[1:0]},
        "R9 fields", {26'd0, bank_sel, pair_xfer, prec_double, denorm_flush, rnd_mode},
        {26'd0, exp_ctrl[21], exp_ctrl[20], exp_ctrl[19], exp_ctrl[18], exp_ctrl[1:0]});
    for (int i = 0; i < 16; i++)
      if (gpr_b[i] != exp_gpr[i]) chk(1'b0, "R7 gpr contents", gpr_b[i], exp_gpr[i]);
  endtask

  task automatic exec(input logic [15:0] w, input bit noise);
    int          k, lat;
    logic [3:0]  n;
    bit          sc;
    logic [31:0] sel, rn, rd, wb, nv;
    k   = kind_of(w);
    n   = w[11:8];
    sc  = w[4];
    sel = sc ? exp_comm : exp_ctrl;
    rn  = exp_gpr[n];
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    #1;
    chk(illegal == (k == 5), "R8 illegal flag", {31'd0, illegal}, {31'd0, k == 5});
    if (k == 1) begin
      chk(gpr_we && gpr_idx == n, "R3 write strobe", {27'd0, gpr_we, gpr_idx}, {27'd0, 1'b1, n});
      chk(gpr_wdata == sel, "R2 R3 selected value", gpr_wdata, sel);
      exp_gpr[n] = sel;
    end else begin
      chk(!gpr_we, "R8 no gpr write", {31'd0, gpr_we}, 32'd0);
    end
    if (k == 2) begin
      if (sc) exp_comm = rn; else exp_ctrl = rn & WMASK;
    end
    @(negedge clk);
    instr_valid = 1'b0;
    if (k == 3 || k == 4) begin
      lat = $urandom % 4;
      wb  = (k == 3) ? rn - 32'd4 : rn + 32'd4;
      for (int i = 0; ; i++) begin
        #1;
        chk(mem_req && busy && mem_we == (k == 3), "R5 R6 request",
            {29'd0, mem_req, busy, mem_we}, {29'd0, 1'b1, 1'b1, k == 3});
        chk(mem_addr == ((k == 3) ? rn - 32'd4 : rn), "R5 R6 R11 address", mem_addr,
            (k == 3) ? rn - 32'd4 : rn);
        if (k == 3) chk(mem_wdata == sel, "R5 R11 store data", mem_wdata, sel);
        if (i == lat) begin
          rd = $urandom;
          mem_ready = 1'b1;
          mem_rdata = rd;
          #1;
          chk(gpr_we && gpr_idx == n, "R7 writeback strobe", {27'd0, gpr_we, gpr_idx}, {27'd0, 1'b1, n});
          chk(gpr_wdata == wb, "R7 writeback value", gpr_wdata, wb);
          exp_gpr[n] = wb;
          if (k == 4) begin
            if (sc) exp_comm = rd; else exp_ctrl = rd & WMASK;
          end
          @(negedge clk);
          mem_ready = 1'b0;
          break;
        end else begin
          chk(!gpr_we, "R7 no early writeback", {31'd0, gpr_we}, 32'd0);
          if (noise) begin
            instr_valid = 1'b1;
            nv = $urandom;
            instr_word = (($urandom % 2) == 0) ? nv[15:0] : 16'h005A;
            #1;
            chk(!illegal && !gpr_we, "R10 ignored while busy", {30'd0, illegal, gpr_we}, 32'd0);
          end
          @(negedge clk);
          instr_valid = 1'b0;
        end
      end
    end
    #1;
    chk(!busy && !mem_req, "R5 busy released", {30'd0, busy, mem_req}, 32'd0);
    compare_state("R2 R4 R6 register state");
  endtask

  function automatic logic [15:0] legal_word();
    logic [7:0]  lo;
    logic [3:0]  hi;
    int          c;
    c = $urandom % 8;
    case (c)
      0: begin hi = 4'h0; lo = 8'h5A; end
      1: begin hi = 4'h0; lo = 8'h6A; end
      2: begin hi = 4'h4; lo = 8'h5A; end
      3: begin hi = 4'h4; lo = 8'h6A; end
      4: begin hi = 4'h4; lo = 8'h52; end
      5: begin hi = 4'h4; lo = 8'h62; end
      6: begin hi = 4'h4; lo = 8'h56; end
      default: begin hi = 4'h4; lo = 8'h66; end
    endcase
    return {hi, 4'($urandom % 16), lo};
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seedv;
    checks = 0;
    fails  = 0;
    seedv  = $urandom(32'd1234);
    instr_valid = 1'b0;
    instr_word  = '0;
    mem_ready   = 1'b0;
    mem_rdata   = '0;
    for (int i = 0; i < 16; i++) begin
      gpr_b[i]   = $urandom;
      exp_gpr[i] = gpr_b[i];
    end
    rst_n = 1'b0;
    exp_ctrl = RST_VAL & WMASK;
    exp_comm = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(ctrl_word == (RST_VAL & WMASK), "R1 reset control", ctrl_word, RST_VAL & WMASK);
    chk(comm_word == 32'd0, "R1 reset transfer reg", comm_word, 32'd0);
    chk(!busy && !mem_req, "R1 reset idle", {30'd0, busy, mem_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 mask: all ones into control word, then read back with R3
    gpr_b[3] = 32'hFFFF_FFFF; exp_gpr[3] = 32'hFFFF_FFFF;
    exec(16'h436A, 1'b0);
    exec(16'h056A, 1'b0);
    // R2 transfer register path
    gpr_b[7] = 32'hDEAD_BEEF; exp_gpr[7] = 32'hDEAD_BEEF;
    exec(16'h475A, 1'b0);
    exec(16'h0F5A, 1'b0);
    // R5 push from address zero wraps
    gpr_b[2] = 32'h0; exp_gpr[2] = 32'h0;
    exec(16'h4252, 1'b1);
    // R6 pop from top of space wraps to zero
    gpr_b[9] = 32'hFFFF_FFFC; exp_gpr[9] = 32'hFFFF_FFFC;
    exec(16'h4966, 1'b1);
    // R8 near-miss words
    exec(16'h405B, 1'b0);
    exec(16'h105A, 1'b0);
    exec(16'hF05A, 1'b0);
    exec(16'h4072, 1'b0);

    for (int t = 0; t < 400; t++) begin
      if (($urandom % 5) == 0) exec(16'($urandom), 1'b1);
      else exec(legal_word(), 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule